// File: doc/BRIEF.md
# Shared Multi-Line Receive Silo

This block gathers characters from several serial receive lines into a single shared FIFO, called the silo. Each line hands over a character with a one-cycle strobe and two error flags. The character first lands in a one-deep staging slot for that line. A fixed-priority arbiter then moves at most one staged character into the silo per cycle. Each stored entry keeps the character, the number of the line it came from, and its parity-error, framing-error and overrun flags.

The host reads the silo one entry at a time through a 16-bit receive-buffer word, and each read removes the entry it returns. The host keeps reading until it gets a word whose valid bit is clear. A three-bit control word sets the receive-interrupt behaviour. With the alarm off, the interrupt is raised while the silo holds anything. With the alarm on, it is raised only once a threshold number of characters is waiting. Clearing the scan enable empties the silo and the staging slots. The line field holds up to four bits, so NUM_LINES may be at most 16.

Top module: `rx_silo`

## Requirements
- R1: A receive-buffer word for a stored entry has these fields:
  - bits 7:0 hold the character;
  - the line number starts at bit 8 (bits 10:8 for 8 lines);
  - bit 11 is zero;
  - bit 12 is the parity error, bit 13 the framing error and bit 14 the overrun flag;
  - bit 15 is the valid bit, set to 1.
- R2: A read of the receive buffer (register address 1) returns the oldest entry and removes it, so entries come out in arrival order. A read while the silo is empty returns 16'h0000 and changes nothing.
- R3: The silo holds at most DEPTH (64) entries, and its occupancy never exceeds DEPTH.
- R4: When several lines strobe in the same cycle, their characters are stored one per cycle, lowest line number first.
- R5: Each line has one staging slot, which is held while the silo is full. A strobe on a line whose slot is still occupied is dropped. The next entry stored into the silo then carries the overrun flag, and the flag clears after that one entry.
- R6: A break is delivered as a received character with the framing error set and data 8'h00. It is stored unchanged as data 0 with bit 13 set.
- R7: With the alarm off and the interrupt enable on, irq_o is high exactly while the silo is non-empty.
- R8: With the alarm on, irq_o is high only while at least ALARM_LEVEL (16) entries are queued.
- R9: With the interrupt enable (control bit 1) clear, irq_o stays low.
- R10: Writing the control word with the scan enable (bit 0) clear empties the silo and the staging slots. Strobes are ignored while the scan enable is clear.
- R11: The control word at register address 0 reads back its three bits: scan enable in bit 0, interrupt enable in bit 1, alarm enable in bit 2. All other bits read as zero.
- R12: After reset, the control word reads 0, the silo is empty and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_strobe_i | input | NUM_LINES | Per-line character-valid strobe |
| rx_data_i | input | 8*NUM_LINES | Per-line character; line n uses bits 8n+7:8n |
| rx_ferr_i | input | NUM_LINES | Per-line framing-error flag |
| rx_perr_i | input | NUM_LINES | Per-line parity-error flag |
| reg_addr_i | input | 1 | 0 selects the control word, 1 selects the receive buffer |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_re_i | input | 1 | Read strobe; at address 1 it pops one entry |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected address (combinational) |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions check several properties on every cycle:
- the occupancy bound;
- that the valid bit agrees with the occupancy;
- that a read with no push in the same cycle lowers the occupancy by exactly one;
- that the silo is empty two cycles after a write clearing the scan enable;
- that irq_o stays low with the enable off;
- that with the alarm on, irq_o is never high below the threshold.

Some behaviour only the bench scenarios can show:
- arrival order and lowest-line-first priority;
- the exact field contents of each word;
- the one-shot overrun tagging after a dropped character;
- break delivery;
- the exact cycle at which the alarm threshold is crossed.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int CTRL_SCAN_BIT  = 0;
  localparam int CTRL_RXIE_BIT  = 1;
  localparam int CTRL_ALARM_BIT = 2;

  localparam int RBUF_LINE_LSB  = 8;
  localparam int RBUF_PE_BIT    = 12;
  localparam int RBUF_FE_BIT    = 13;
  localparam int RBUF_OVR_BIT   = 14;
  localparam int RBUF_VALID_BIT = 15;

  typedef struct packed {
    logic       ovr;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_char_t;
endpackage

// File: rtl/rx_silo_stage.sv
module rx_silo_stage
  import rx_silo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       strobe_i,
  input  logic [7:0] data_i,
  input  logic       fe_i,
  input  logic       pe_i,
  input  logic       take_i,
  output logic       full_o,
  output rx_char_t   char_o,
  output logic       drop_o
);
  logic     full_q;
  rx_char_t char_q;
  logic     load;

  assign load   = strobe_i && (!full_q || take_i);
  assign drop_o = strobe_i && full_q && !take_i;
  assign full_o = full_q;
  assign char_o = char_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      char_q <= '0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else if (load) begin
      full_q      <= 1'b1;
      char_q.data <= data_i;
      char_q.fe   <= fe_i;
      char_q.pe   <= pe_i;
      char_q.ovr  <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_silo_arb.sv
module rx_silo_arb #(
  parameter int N      = 8,
  parameter int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
  parameter int W     = 14,
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_LINES-1:0]   rx_strobe_i,
  input  logic [8*NUM_LINES-1:0] rx_data_i,
  input  logic [NUM_LINES-1:0]   rx_ferr_i,
  input  logic [NUM_LINES-1:0]   rx_perr_i,
  input  logic                   reg_addr_i,
  input  logic                   reg_we_i,
  input  logic                   reg_re_i,
  input  logic [15:0]            reg_wdata_i,
  output logic [15:0]            reg_rdata_o,
  output logic                   irq_o
);
  localparam int LINE_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CHAR_W  = $bits(rx_char_t);
  localparam int ENTRY_W = LINE_W + CHAR_W;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic scan_en, rx_ie, alarm_en;
  logic ovr_pend_q;

  logic [NUM_LINES-1:0] stg_full, stg_drop, stg_take, grant;
  rx_char_t             stg_char [NUM_LINES];
  logic [LINE_W-1:0]    win_idx;
  logic                 win_any;

  logic               silo_push, silo_pop, silo_full, silo_empty;
  logic [ENTRY_W-1:0] silo_wdata, silo_rdata;
  logic [CNT_W-1:0]   silo_count;
  rx_char_t           win_char, head_char;
  logic [LINE_W-1:0]  head_line;
  logic [15:0]        rbuf_word, ctrl_word;

  // control word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_en  <= 1'b0;
      rx_ie    <= 1'b0;
      alarm_en <= 1'b0;
    end else if (reg_we_i && !reg_addr_i) begin
      scan_en  <= reg_wdata_i[CTRL_SCAN_BIT];
      rx_ie    <= reg_wdata_i[CTRL_RXIE_BIT];
      alarm_en <= reg_wdata_i[CTRL_ALARM_BIT];
    end
  end

  // per-line staging slots
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    rx_silo_stage u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (!scan_en),
      .strobe_i (rx_strobe_i[g] && scan_en),
      .data_i   (rx_data_i[8*g +: 8]),
      .fe_i     (rx_ferr_i[g]),
      .pe_i     (rx_perr_i[g]),
      .take_i   (stg_take[g]),
      .full_o   (stg_full[g]),
      .char_o   (stg_char[g]),
      .drop_o   (stg_drop[g])
    );
  end

  rx_silo_arb #(.N(NUM_LINES), .IDX_W(LINE_W)) u_arb (
    .req_i   (stg_full),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (win_any)
  );

  assign stg_take  = grant & {NUM_LINES{!silo_full}};
  assign silo_push = win_any && !silo_full && scan_en;

  always_comb begin
    win_char     = stg_char[win_idx];
    win_char.ovr = ovr_pend_q;
  end
  assign silo_wdata = {win_idx, win_char};

  // one-shot overrun tag for the next stored entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ovr_pend_q <= 1'b0;
    else if (!scan_en)      ovr_pend_q <= 1'b0;
    else if (|stg_drop)     ovr_pend_q <= 1'b1;
    else if (silo_push)     ovr_pend_q <= 1'b0;
  end

  assign silo_pop = reg_re_i && reg_addr_i && !silo_empty;

  rx_silo_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!scan_en),
    .push_i  (silo_push),
    .wdata_i (silo_wdata),
    .pop_i   (silo_pop),
    .rdata_o (silo_rdata),
    .count_o (silo_count),
    .full_o  (silo_full),
    .empty_o (silo_empty)
  );

  assign head_char = silo_rdata[CHAR_W-1:0];
  assign head_line = silo_rdata[ENTRY_W-1:CHAR_W];

  always_comb begin
    rbuf_word = '0;
    if (!silo_empty) begin
      rbuf_word[7:0]                     = head_char.data;
      rbuf_word[RBUF_LINE_LSB +: LINE_W] = head_line;
      rbuf_word[RBUF_PE_BIT]             = head_char.pe;
      rbuf_word[RBUF_FE_BIT]             = head_char.fe;
      rbuf_word[RBUF_OVR_BIT]            = head_char.ovr;
      rbuf_word[RBUF_VALID_BIT]          = 1'b1;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_SCAN_BIT]  = scan_en;
    ctrl_word[CTRL_RXIE_BIT]  = rx_ie;
    ctrl_word[CTRL_ALARM_BIT] = alarm_en;
  end

  assign reg_rdata_o = reg_addr_i ? rbuf_word : ctrl_word;

  assign irq_o = rx_ie && (alarm_en ? (silo_count >= CNT_W'(ALARM_LEVEL)) : !silo_empty);
endmodule

// File: rtl/rx_silo_checker.sv
module rx_silo_checker #(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_addr_i,
  input logic             reg_we_i,
  input logic             reg_re_i,
  input logic             scan_wbit_i,
  input logic             valid_bit_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] count_i,
  input logic             alarm_en_i,
  input logic             rx_ie_i,
  input logic             push_i
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  a_r2_valid_tracks_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i |-> (valid_bit_i == (count_i != '0)));

  a_r2_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i && count_i != '0 && !push_i) |=> (count_i == $past(count_i) - 1'b1));

  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && !scan_wbit_i) |=> ##1 (count_i == '0));

  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ie_i |-> !irq_i);

  a_r8_alarm_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && alarm_en_i) |-> (count_i >= CNT_W'(ALARM_LEVEL)));
endmodule

bind rx_silo rx_silo_checker #(.DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .scan_wbit_i (reg_wdata_i[0]),
  .valid_bit_i (reg_rdata_o[15]),
  .irq_i       (irq_o),
  .count_i     (silo_count),
  .alarm_en_i  (alarm_en),
  .rx_ie_i     (rx_ie),
  .push_i      (silo_push)
);

// File: tb/rx_silo_bench.sv
module rx_silo_bench;
  localparam int NL = 8;
  localparam int DEPTH = 64;
  localparam int ALARM = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] rx_strobe_i = '0;
  logic [8*NL-1:0] rx_data_i = '0;
  logic [NL-1:0] rx_ferr_i = '0;
  logic [NL-1:0] rx_perr_i = '0;
  logic          reg_addr_i = 1'b0;
  logic          reg_we_i = 1'b0;
  logic          reg_re_i = 1'b0;
  logic [15:0]   reg_wdata_i = '0;
  logic [15:0]   reg_rdata_o;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] exp_q [$];

  always #5 clk_i = ~clk_i;

  rx_silo #(.NUM_LINES(NL), .DEPTH(DEPTH), .ALARM_LEVEL(ALARM)) u_rx_silo (.*);

  function automatic logic [15:0] mk_word(int ln, logic [7:0] d, logic ovr, logic fe, logic pe);
    logic [2:0] l3 = 3'(ln);
    return {1'b1, ovr, fe, pe, 1'b0, l3, d};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_ctrl(logic [2:0] v);
    @(negedge clk_i);
    reg_addr_i = 1'b0; reg_we_i = 1'b1; reg_wdata_i = {13'b0, v};
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_ctrl(output logic [15:0] v);
    @(negedge clk_i);
    reg_addr_i = 1'b0;
    #1 v = reg_rdata_o;
  endtask

  task automatic pop(output logic [15:0] v);
    @(negedge clk_i);
    reg_addr_i = 1'b1; reg_re_i = 1'b1;
    #1 v = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic pop_chk(string req);
    logic [15:0] v, e;
    pop(v);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0000;
    chk(req, v, e);
  endtask

  task automatic strobe(logic [NL-1:0] m, logic [8*NL-1:0] d, logic [NL-1:0] fe, logic [NL-1:0] pe);
    @(negedge clk_i);
    rx_strobe_i = m; rx_data_i = d; rx_ferr_i = fe; rx_perr_i = pe;
    @(negedge clk_i);
    rx_strobe_i = '0;
  endtask

  task automatic one(int ln, logic [7:0] d, logic fe, logic pe);
    logic [8*NL-1:0] dv = '0;
    dv[8*ln +: 8] = d;
    strobe(NL'(1) << ln, dv, NL'(fe) << ln, NL'(pe) << ln);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [8*NL-1:0] d;
    logic [NL-1:0] m, fe, pe;
    void'($urandom(32'd20240611));
    tick(3);
    rst_ni = 1'b1;

    // R12 reset state
    rd_ctrl(v); chk("R12 ctrl", v, 16'h0000);
    #1 chk("R12 irq", {15'b0, irq_o}, 16'h0000);
    pop(v); chk("R12 empty", v, 16'h0000);

    // R11 readback
    wr_ctrl(3'b101); rd_ctrl(v); chk("R11 ctrl readback", v, 16'h0005);
    wr_ctrl(3'b011); rd_ctrl(v); chk("R11 ctrl readback", v, 16'h0003);

    // R1, R6, R7
    one(5, 8'h41, 1'b0, 1'b1); exp_q.push_back(mk_word(5, 8'h41, 0, 0, 1));
    one(3, 8'h00, 1'b1, 1'b0); exp_q.push_back(mk_word(3, 8'h00, 0, 1, 0));
    tick(3);
    #1 chk("R7 irq nonempty", {15'b0, irq_o}, 16'h0001);
    pop_chk("R1 fields");
    pop_chk("R6 break");
    tick(1);
    #1 chk("R7 irq empty", {15'b0, irq_o}, 16'h0000);
    pop(v); chk("R2 empty read", v, 16'h0000);

    // R4 simultaneous strobes
    d = '0;
    for (int i = 0; i < NL; i++) d[8*i +: 8] = 8'(8'h10 + i);
    strobe(8'b1010_0110, d, 8'b0000_0100, 8'b1000_0000);
    exp_q.push_back(mk_word(1, 8'h11, 0, 0, 0));
    exp_q.push_back(mk_word(2, 8'h12, 0, 1, 0));
    exp_q.push_back(mk_word(5, 8'h15, 0, 0, 0));
    exp_q.push_back(mk_word(7, 8'h17, 0, 0, 1));
    tick(10);
    repeat (4) pop_chk("R4 priority");

    // R2/R7 random traffic
    for (int it = 0; it < 60; it++) begin
      m = NL'($urandom);
      if (m == '0) m = 8'h01;
      for (int i = 0; i < NL; i++) begin
        d[8*i +: 8] = 8'($urandom);
        fe[i] = ($urandom % 4 == 0);
        pe[i] = ($urandom % 4 == 0);
      end
      strobe(m, d, fe, pe);
      for (int i = 0; i < NL; i++)
        if (m[i]) exp_q.push_back(mk_word(i, d[8*i +: 8], 0, fe[i], pe[i]));
      tick(10);
      #1 chk("R7 irq random", {15'b0, irq_o}, {15'b0, exp_q.size() != 0});
      begin
        int k = $urandom % (exp_q.size() + 1);
        if (exp_q.size() > 40) k = exp_q.size() - 20;
        for (int j = 0; j < k; j++) pop_chk("R2 order random");
      end
    end
    while (exp_q.size() != 0) pop_chk("R2 drain");
    pop(v); chk("R2 empty after drain", v, 16'h0000);

    // R9 masked
    wr_ctrl(3'b001);
    one(0, 8'h77, 0, 0); tick(3);
    #1 chk("R9 irq masked", {15'b0, irq_o}, 16'h0000);
    exp_q.push_back(mk_word(0, 8'h77, 0, 0, 0));
    pop_chk("R9 data kept");

    // R8 alarm threshold
    wr_ctrl(3'b111);
    for (int i = 0; i < ALARM - 1; i++) begin
      one(1, 8'(i), 0, 0);
      exp_q.push_back(mk_word(1, 8'(i), 0, 0, 0));
    end
    tick(3);
    #1 chk("R8 below level", {15'b0, irq_o}, 16'h0000);
    one(1, 8'hF0, 0, 0); exp_q.push_back(mk_word(1, 8'hF0, 0, 0, 0));
    tick(3);
    #1 chk("R8 at level", {15'b0, irq_o}, 16'h0001);
    pop_chk("R8 pop");
    tick(1);
    #1 chk("R8 dropped below", {15'b0, irq_o}, 16'h0000);

    // R10 flush
    wr_ctrl(3'b000);
    exp_q.delete();
    one(4, 8'h99, 0, 0);
    tick(3);
    wr_ctrl(3'b011);
    tick(2);
    pop(v); chk("R10 flushed", v, 16'h0000);
    #1 chk("R10 irq after flush", {15'b0, irq_o}, 16'h0000);

    // R3/R5 full silo and overrun
    wr_ctrl(3'b001);
    for (int i = 0; i < DEPTH; i++) begin
      one(0, 8'(i), 0, 0);
      exp_q.push_back(mk_word(0, 8'(i), 0, 0, 0));
    end
    one(2, 8'hA5, 0, 0); tick(3);
    one(2, 8'h5A, 0, 0); tick(3);
    exp_q.push_back(mk_word(2, 8'hA5, 1, 0, 0));
    pop_chk("R3 head when full");
    tick(3);
    for (int i = 1; i < DEPTH; i++) pop_chk("R3 contents");
    pop_chk("R5 overrun tagged");
    pop(v); chk("R5 dropped char absent", v, 16'h0000);
    one(6, 8'h33, 0, 0); tick(3);
    exp_q.push_back(mk_word(6, 8'h33, 0, 0, 0));
    pop_chk("R5 overrun one-shot");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule